// File: doc/BRIEF.md
# Four-Stage Interlocked Integer Pipeline

This block is a small in-order processor core with four stages, fetch, decode, execute and writeback, and a register latch between each pair of stages. It runs two instructions. The first is an add whose two source operands each come from a register or from the immediate field. The second is a halt. The core reads its program through an instruction-memory port: it drives a word address and samples the returned word at the clock edge. When a halt has travelled down to writeback, the core raises a halted flag. The register file can be read at any time through a debug port.

The core has no operand forwarding. If an instruction reads the register written by the instruction just ahead of it, decode detects the dependency. In that cycle fetch freezes, and a bubble goes to execute in place of the decoded instruction. One cycle later the producer writes its result back. A write-first path in the register file makes that new value visible to the re-issued instruction in the same cycle. So each such dependency costs exactly one stall cycle.

Top module: `intPipe4`

## Requirements
- R1: While reset is held and directly after it: halted is 0, imemAddr is 0, and every register reads 0 on the debug port. Every stage latch holds the bubble word `add r30 = r30 + r30, imm 0`.
- R2: Instruction word fields: bits 31:28 are the opcode (0 = add, 1 = halt), bits 27:23 the destination, bits 22:18 operand a, bits 17:13 operand b, and bits 12:0 the immediate. An add writes value(a) + value(b), modulo 2^32, into the destination.
- R3: Operand index 29 takes the immediate, zero-extended to 32 bits, in place of a register. Register 30 always reads 0, and writes to it are dropped.
- R4: Without stalls, one instruction enters per cycle. Count clock edges from the first edge after reset is released. With a halt at word address k, halted is first high after edge k+4.
- R5: An add that reads the destination of the add just ahead of it stalls the front of the pipeline for exactly one cycle. A dependency at a distance of two or more instructions costs no stall. In both cases the consumer sees the producer's result. Two stall cycles never occur back to back.
- R6: Operand indices 29 and 30 never trigger a stall, whatever the destination ahead. A producer whose destination is 30 never causes a stall.
- R7: After a halt is fetched, imemAddr stops advancing and bubbles enter the pipeline. Words after the halt have no effect on any register. Halted stays high until reset.
- R8: An opcode other than 0 or 1 is treated as a bubble. It writes nothing and causes no stall in the instruction that follows it.
- R9: dbgData shows, combinationally, the register selected by dbgAddr. Register 30 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| imemAddr | output | PC_W | Word address of the next instruction |
| imemData | input | 32 | Instruction word at imemAddr, sampled at the clock edge |
| halted | output | 1 | High once a halt has reached writeback |
| dbgAddr | input | 5 | Register index for the debug read |
| dbgData | output | 32 | Value of the selected register |

## Verification
Independent immediate adds set the base latency and throughput. A chain of +1 operations on one register forces a stall on every instruction. A sweep places a producer one, two or three slots ahead of a consumer that reads it through a, b or both. This separates the stall at distance one from no stall at larger distances, and separates correct results from stale ones. A second sweep runs operand a over all 32 indices against a fixed destination, which shows that exactly one index stalls and that 29 and 30 stay exempt. Further programs place words after a halt and use unknown opcodes, to show that neither touches the registers.

// File: rtl/pipePkg.sv
package pipePkg;
  localparam int XLEN   = 32;
  localparam int OP_W   = 4;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 13;
  localparam int NREGS  = 1 << RIDX_W;

  localparam logic [RIDX_W-1:0] REG_IMM  = RIDX_W'(29);
  localparam logic [RIDX_W-1:0] REG_ZERO = RIDX_W'(30);
  localparam logic [OP_W-1:0]   OP_ADD   = OP_W'(0);
  localparam logic [OP_W-1:0]   OP_HALT  = OP_W'(1);

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] srcA;
    logic [RIDX_W-1:0] srcB;
    logic [IMM_W-1:0]  imm;
  } instr_t;

  localparam instr_t BUBBLE = '{op: OP_ADD, dst: REG_ZERO, srcA: REG_ZERO,
                                srcB: REG_ZERO, imm: '0};

  typedef struct packed {
    logic              wrEn;
    logic              isHalt;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   opA;
    logic [XLEN-1:0]   opB;
  } dec_t;

  typedef struct packed {
    logic              wrEn;
    logic              isHalt;
    logic [RIDX_W-1:0] dst;
    logic [XLEN-1:0]   result;
  } ex_t;

  typedef struct packed {
    logic stall;
    logic fetchIdle;
  } strobe_t;
endpackage

// File: rtl/pipeCtrl.sv
module pipeCtrl
  import pipePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   fetchOp,
  input  logic [RIDX_W-1:0] fetchSrcA,
  input  logic [RIDX_W-1:0] fetchSrcB,
  input  logic              decWrEn,
  input  logic [RIDX_W-1:0] decDst,
  input  logic              exIsHalt,
  output strobe_t           strobes,
  output logic              halted
);
  logic haltSeenQ;
  logic haltedQ;
  logic hitA, hitB;

  function automatic logic isReserved(input logic [RIDX_W-1:0] idx);
    return (idx == REG_IMM) || (idx == REG_ZERO);
  endfunction

  always_comb begin
    hitA = (fetchSrcA == decDst) && !isReserved(fetchSrcA);
    hitB = (fetchSrcB == decDst) && !isReserved(fetchSrcB);
    strobes.stall     = (fetchOp == OP_ADD) && decWrEn && (hitA || hitB);
    strobes.fetchIdle = haltSeenQ || (fetchOp == OP_HALT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltSeenQ <= 1'b0;
      haltedQ   <= 1'b0;
    end else begin
      haltSeenQ <= strobes.fetchIdle;
      haltedQ   <= haltedQ || exIsHalt;
    end
  end

  assign halted = haltedQ;

  // R5: a stall releases the consumer after one cycle
  p_single_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |=> !strobes.stall);

  // R7: halted is sticky
  p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R6: reserved indices never raise a stall
  p_reserved_free_r6: assert property (@(posedge clk) disable iff (!rstN)
    (isReserved(fetchSrcA) && isReserved(fetchSrcB)) |-> !strobes.stall);
endmodule

// File: rtl/pipeData.sv
module pipeData
  import pipePkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [XLEN-1:0]   imemData,
  output logic [OP_W-1:0]   fetchOp,
  output logic [RIDX_W-1:0] fetchSrcA,
  output logic [RIDX_W-1:0] fetchSrcB,
  output logic              decWrEn,
  output logic [RIDX_W-1:0] decDst,
  output logic              exIsHalt,
  input  logic [RIDX_W-1:0] dbgAddr,
  output logic [XLEN-1:0]   dbgData
);
  logic [PC_W-1:0] pcQ;
  instr_t          fetchQ;
  dec_t            decQ, decNext;
  ex_t             exQ;
  logic [XLEN-1:0] rf [NREGS];

  function automatic logic [XLEN-1:0] readOperand(input logic [RIDX_W-1:0] idx,
                                                  input logic [IMM_W-1:0] imm);
    logic [XLEN-1:0] v;
    if (idx == REG_ZERO)                 v = '0;
    else if (idx == REG_IMM)             v = {{(XLEN-IMM_W){1'b0}}, imm};
    else if (exQ.wrEn && exQ.dst == idx) v = exQ.result;
    else                                 v = rf[idx];
    return v;
  endfunction

  always_comb begin
    logic isAdd;
    isAdd          = (fetchQ.op == OP_ADD);
    decNext.wrEn   = isAdd && (fetchQ.dst != REG_ZERO);
    decNext.isHalt = (fetchQ.op == OP_HALT);
    decNext.dst    = isAdd ? fetchQ.dst : REG_ZERO;
    decNext.opA    = isAdd ? readOperand(fetchQ.srcA, fetchQ.imm) : '0;
    decNext.opB    = isAdd ? readOperand(fetchQ.srcB, fetchQ.imm) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ    <= '0;
      fetchQ <= BUBBLE;
      decQ   <= '{wrEn: 1'b0, isHalt: 1'b0, dst: REG_ZERO, opA: '0, opB: '0};
      exQ    <= '{wrEn: 1'b0, isHalt: 1'b0, dst: REG_ZERO, result: '0};
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else begin
      if (!strobes.stall && !strobes.fetchIdle) pcQ <= pcQ + 1'b1;
      if (!strobes.stall) fetchQ <= strobes.fetchIdle ? BUBBLE : instr_t'(imemData);
      if (strobes.stall)
        decQ <= '{wrEn: 1'b0, isHalt: 1'b0, dst: REG_ZERO, opA: '0, opB: '0};
      else
        decQ <= decNext;
      exQ <= '{wrEn: decQ.wrEn, isHalt: decQ.isHalt, dst: decQ.dst,
               result: decQ.opA + decQ.opB};
      if (exQ.wrEn) rf[exQ.dst] <= exQ.result;
    end
  end

  assign imemAddr  = pcQ;
  assign fetchOp   = fetchQ.op;
  assign fetchSrcA = fetchQ.srcA;
  assign fetchSrcB = fetchQ.srcB;
  assign decWrEn   = decQ.wrEn;
  assign decDst    = decQ.dst;
  assign exIsHalt  = exQ.isHalt;
  assign dbgData   = (dbgAddr == REG_ZERO) ? '0 : rf[dbgAddr];

  // R3: nothing headed for writeback targets the zero register
  p_no_zero_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    exQ.wrEn |-> exQ.dst != REG_ZERO);

  // R5: the slot behind a stall carries a bubble
  p_stall_bubble_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |=> (!decQ.wrEn && !decQ.isHalt));

  // R7: once the front is idle the fetch address is frozen
  p_pc_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fetchIdle |=> $stable(imemAddr));

  // R5: a held fetch keeps its address
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |=> $stable(imemAddr));
endmodule

// File: rtl/intPipe4.sv
module intPipe4
  import pipePkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [PC_W-1:0]   imemAddr,
  input  logic [XLEN-1:0]   imemData,
  output logic              halted,
  input  logic [RIDX_W-1:0] dbgAddr,
  output logic [XLEN-1:0]   dbgData
);
  strobe_t           strobes;
  logic [OP_W-1:0]   fetchOp;
  logic [RIDX_W-1:0] fetchSrcA, fetchSrcB, decDst;
  logic              decWrEn, exIsHalt;

  pipeCtrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .fetchOp(fetchOp), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .decWrEn(decWrEn), .decDst(decDst), .exIsHalt(exIsHalt),
    .strobes(strobes), .halted(halted)
  );

  pipeData #(.PC_W(PC_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .imemAddr(imemAddr), .imemData(imemData),
    .fetchOp(fetchOp), .fetchSrcA(fetchSrcA), .fetchSrcB(fetchSrcB),
    .decWrEn(decWrEn), .decDst(decDst), .exIsHalt(exIsHalt),
    .dbgAddr(dbgAddr), .dbgData(dbgData)
  );
endmodule

// File: tb/intPipe4_bench.sv
module intPipe4_bench;
  localparam int PC_W = 8;
  localparam int MEMD = 1 << PC_W;
  localparam logic [31:0] BUB = {4'd0, 5'd30, 5'd30, 5'd30, 13'd0};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] imemAddr;
  logic [31:0]     imemData;
  logic            halted;
  logic [4:0]      dbgAddr = '0;
  logic [31:0]     dbgData;
  logic [31:0]     mem [MEMD];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;
  assign imemData = mem[imemAddr];

  intPipe4 #(.PC_W(PC_W)) u_intPipe4 (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .halted(halted), .dbgAddr(dbgAddr), .dbgData(dbgData)
  );

  function automatic logic [31:0] enc(input int op, input int d, input int a,
                                      input int b, input int imm);
    return {op[3:0], d[4:0], a[4:0], b[4:0], imm[12:0]};
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < MEMD; i++) mem[i] = BUB;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Sequential model of the program plus arithmetic stall count.
  task automatic model(output logic [31:0] regs [32], output int edges);
    int stalls = 0;
    bit prevWr = 0;
    int prevDst = 30;
    int pc = 0;
    for (int i = 0; i < 32; i++) regs[i] = '0;
    while (pc < MEMD && mem[pc][31:28] != 4'd1) begin
      logic [31:0] w;
      int op, d, a, b;
      logic [31:0] va, vb;
      w = mem[pc]; op = w[31:28]; d = w[27:23]; a = w[22:18]; b = w[17:13];
      if (op == 0) begin
        if (prevWr && ((a == prevDst && a != 29 && a != 30) ||
                       (b == prevDst && b != 29 && b != 30))) stalls++;
        va = (a == 30) ? 0 : (a == 29) ? {19'd0, w[12:0]} : regs[a];
        vb = (b == 30) ? 0 : (b == 29) ? {19'd0, w[12:0]} : regs[b];
        if (d != 30) regs[d] = va + vb;
        prevWr = (d != 30); prevDst = d;
      end else begin
        prevWr = 0;
      end
      pc++;
    end
    edges = pc + 4 + stalls;
  endtask

  task automatic runProg(input string tag);
    logic [31:0] exp [32];
    int expEdges, cnt;
    model(exp, expEdges);
    doReset();
    cnt = 0;
    while (!halted && cnt < 600) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    chk({tag, " R4 R5 edges to halted"}, cnt, expEdges);
    for (int r = 0; r < 32; r++) begin
      dbgAddr = r[4:0]; #1;
      chk({tag, " R2 R3 R9 reg value"}, dbgData, exp[r]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [PC_W-1:0] addrHold;
    clearMem();
    // R1: state under reset
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 halted in reset", halted, 0);
    chk("R1 imemAddr in reset", imemAddr, 0);
    for (int r = 0; r < 32; r++) begin
      dbgAddr = r[4:0]; #1;
      chk("R1 reg zero in reset", dbgData, 0);
    end

    // R2 R4: independent immediate adds
    clearMem();
    for (int i = 0; i < 4; i++) mem[i] = enc(0, i + 1, i + 1, 29, 15);
    mem[4] = enc(1, 0, 0, 0, 0);
    runProg("indep");

    // R5: dependent +1 chain
    clearMem();
    mem[0] = enc(0, 0, 30, 29, 1);
    for (int i = 1; i < 4; i++) mem[i] = enc(0, 0, 0, 29, 1);
    mem[4] = enc(1, 0, 0, 0, 0);
    runProg("chain R5");

    // R5: distance x operand position x producer sweep
    for (int d = 1; d <= 3; d++)
      for (int pos = 0; pos < 3; pos++)
        for (int pi = 0; pi < 3; pi++) begin
          int p = (pi == 0) ? 1 : (pi == 1) ? 17 : 31;
          clearMem();
          mem[0] = enc(0, p, 30, 29, 100 + d * 7 + pos);
          for (int f = 1; f < d; f++) mem[f] = enc(0, 9, 9, 29, 3);
          mem[d] = enc(0, 12, (pos != 1) ? p : 29, (pos != 0) ? p : 29, 5);
          mem[d + 1] = enc(1, 0, 0, 0, 0);
          runProg("sweep R5");
        end

    // R6: operand a over every index, producer writes r3
    for (int x = 0; x < 32; x++) begin
      clearMem();
      mem[0] = enc(0, 3, 30, 29, 41);
      mem[1] = enc(0, 3, 29, 29, 2);
      mem[2] = enc(0, 14, x, 29, 6);
      mem[3] = enc(1, 0, 0, 0, 0);
      runProg("opsweep R6");
    end

    // R6 R3: reserved destinations 29 and 30
    clearMem();
    mem[0] = enc(0, 29, 30, 29, 100);
    mem[1] = enc(0, 2, 29, 29, 4);
    mem[2] = enc(0, 30, 30, 29, 9);
    mem[3] = enc(0, 3, 30, 30, 1);
    mem[4] = enc(1, 0, 0, 0, 0);
    runProg("reserved R6");

    // R8: unknown opcode has no effect and no stall
    clearMem();
    mem[0] = enc(0, 4, 30, 29, 20);
    mem[1] = enc(5, 4, 29, 29, 77);
    mem[2] = enc(0, 6, 4, 29, 1);
    mem[3] = enc(15, 6, 6, 6, 5);
    mem[4] = enc(1, 0, 0, 0, 0);
    runProg("unknown R8");

    // R7: words after halt are ignored, halted sticky, fetch frozen
    clearMem();
    mem[0] = enc(0, 7, 30, 29, 11);
    mem[1] = enc(0, 8, 7, 29, 1);
    mem[2] = enc(1, 0, 0, 0, 0);
    mem[3] = enc(0, 7, 30, 29, 999);
    mem[4] = enc(0, 8, 30, 29, 888);
    runProg("afterhalt R7");
    addrHold = imemAddr;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 halted stays high", halted, 1);
    chk("R7 imemAddr frozen", imemAddr, addrHold);
    dbgAddr = 5'd7; #1;
    chk("R7 r7 untouched after halt", dbgData, 11);
    dbgAddr = 5'd8; #1;
    chk("R7 r8 untouched after halt", dbgData, 12);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule